// File: doc/BRIEF.md
# Sequential Reed-Solomon Key-Word Generator

This block turns a cipher key of 128, 192 or 256 bits into the key-dependent S words that a Twofish-style round function needs. The key is cut into 64-bit chunks. Each chunk is multiplied by a fixed 4x8 matrix over GF(2^8), and the result is one 32-bit S word. Only one matrix-multiply unit exists. A small sequencer feeds it one chunk per clock cycle and writes each word into a four-entry register file.

A one-cycle start pulse captures the key and the size code. The block then computes for two, three or four cycles and raises a done flag. Any result word can be read at any time through a combinational indexed read port. Start and done are plain level and pulse signals. Nothing is streamed and no back-pressure exists: a start that arrives while the block is computing is dropped. The caller must wait for done before it issues a new start.

Top module: `tf_rs_keygen`

## Requirements
- R1: Key byte n (n = 0..31) is `key_i[255-8n -: 8]`. Chunk c holds bytes 8c..8c+7, and byte 8c+j is vector element m_j. Byte r of S word c (r = 0..3) sits at bits [8r+7:8r], with r = 0 the least significant byte.
- R2: Byte s_r = XOR over j of RS[r][j]·m_j in GF(2^8), reduced by x^8+x^6+x^3+x^2+1 (0x14D). The matrix rows are: r0 = 01 A4 55 87 5A 58 DB 9E, r1 = A4 56 82 F3 1E C6 68 E5, r2 = 02 A1 FC C1 47 AE 3D 19, r3 = A4 55 87 5A 58 DB 9E 03.
- R3: The size code selects the key length:
  - `size_i` 00: 128-bit key in `key_i[255:128]`, producing words 0..1.
  - `size_i` 01: 192-bit key in `key_i[255:64]`, producing words 0..2.
  - `size_i` 10 or 11: 256-bit key, producing words 0..3.

  Chunk c is written to word c. Key bits below the selected length have no effect.
- R4: `done_o` rises exactly N clock edges after the edge that accepts start, where N is the number of words for the selected size. It is low during those cycles.
- R5: A start pulse is accepted only while idle. A start that arrives during a computation is ignored. Key and size are sampled only at an accepted start, so changes to `key_i` or `size_i` during the computation have no effect.
- R6: `done_o` stays high until the next accepted start, which clears it. `rd_word_o` shows word `rd_idx_i` combinationally. Words that a shorter run does not produce keep their previous contents.
- R7: A synchronous active-high `rst` clears `done_o` and stops any computation in progress. A start after reset runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; samples key and size when idle |
| size_i | input | 2 | Key size code (00=128, 01=192, 1x=256) |
| key_i | input | 256 | Key, big-endian, left-aligned |
| done_o | output | 1 | High when all words of the last run are stored |
| rd_idx_i | input | 2 | Word index for the read port |
| rd_word_o | output | 32 | Stored S word at `rd_idx_i` |

## Verification
Single-byte keys each light one matrix column in one chunk, with expected words written as constants. These keys separate byte-order errors, column errors and chunk-to-word routing errors. A key byte of 02 exercises the reduction by the field polynomial. Dense pseudo-random keys at every size code are compared against an independent field model; garbage in the unused low key bits shows whether those bits leak in. Directed runs cover a second start during a computation with a changed key, a shorter run after a longer one, and a reset in the middle of a run.

// File: rtl/tf_rs_pkg.sv
package tf_rs_pkg;
  localparam int GF_W    = 8;
  localparam int RS_ROWS = 4;
  localparam int RS_COLS = 8;

  typedef logic [GF_W-1:0] gf_t;

  typedef enum logic [1:0] {
    KSZ_128  = 2'd0,
    KSZ_192  = 2'd1,
    KSZ_256  = 2'd2,
    KSZ_256X = 2'd3
  } key_size_e;

  localparam gf_t RS_MAT [RS_ROWS][RS_COLS] = '{
    '{8'h01, 8'hA4, 8'h55, 8'h87, 8'h5A, 8'h58, 8'hDB, 8'h9E},
    '{8'hA4, 8'h56, 8'h82, 8'hF3, 8'h1E, 8'hC6, 8'h68, 8'hE5},
    '{8'h02, 8'hA1, 8'hFC, 8'hC1, 8'h47, 8'hAE, 8'h3D, 8'h19},
    '{8'hA4, 8'h55, 8'h87, 8'h5A, 8'h58, 8'hDB, 8'h9E, 8'h03}
  };

  // Shift-and-add product in GF(2^8) reduced by poly (9 bits, MSB set)
  function automatic gf_t gf_mul(input gf_t a, input gf_t b, input logic [GF_W:0] poly);
    logic [GF_W:0] x;
    gf_t           p;
    x = {1'b0, a};
    p = '0;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) p = p ^ x[GF_W-1:0];
      x = x << 1;
      if (x[GF_W]) x = x ^ poly;
    end
    return p;
  endfunction
endpackage

// File: rtl/tf_rs_chunk_sel.sv
module tf_rs_chunk_sel
  import tf_rs_pkg::*;
#(
  parameter int NUM_CHUNKS  = 4,
  parameter int CHUNK_BYTES = 8,
  localparam int KEY_BYTES  = NUM_CHUNKS * CHUNK_BYTES,
  localparam int KEY_W      = KEY_BYTES * GF_W,
  localparam int SEL_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic [KEY_W-1:0] key,
  input  logic [SEL_W-1:0] sel,
  output gf_t              chunk [CHUNK_BYTES]
);
  gf_t kbyte [KEY_BYTES];

  // big-endian byte n of the key
  for (genvar n = 0; n < KEY_BYTES; n++) begin : g_kb
    assign kbyte[n] = key[KEY_W-1-GF_W*n -: GF_W];
  end

  always_comb begin
    for (int j = 0; j < CHUNK_BYTES; j++) begin
      chunk[j] = kbyte[int'(sel) * CHUNK_BYTES + j];
    end
  end
endmodule

// File: rtl/tf_rs_matrix.sv
module tf_rs_matrix
  import tf_rs_pkg::*;
#(
  parameter logic [GF_W:0] POLY = 9'h14D,
  localparam int WORD_W = RS_ROWS * GF_W
) (
  input  gf_t               m [RS_COLS],
  output logic [WORD_W-1:0] s
);
  for (genvar r = 0; r < RS_ROWS; r++) begin : g_row
    gf_t acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < RS_COLS; j++) begin
        acc = acc ^ gf_mul(RS_MAT[r][j], m[j], POLY);
      end
    end
    assign s[GF_W*r +: GF_W] = acc;
  end
endmodule

// File: rtl/tf_rs_wordfile.sv
module tf_rs_wordfile #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/tf_rs_keygen.sv
module tf_rs_keygen
  import tf_rs_pkg::*;
#(
  parameter logic [GF_W:0] POLY = 9'h14D,
  parameter int MAX_CHUNKS      = 4,
  localparam int CHUNK_BYTES    = RS_COLS,
  localparam int WORD_W         = RS_ROWS * GF_W,
  localparam int KEY_W          = MAX_CHUNKS * CHUNK_BYTES * GF_W,
  localparam int CNT_W          = $clog2(MAX_CHUNKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              done_o,
  input  logic [CNT_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q, last_q, last_d;
  logic [KEY_W-1:0] key_q;
  gf_t              chunk [CHUNK_BYTES];
  logic [WORD_W-1:0] s_word;

  always_comb begin
    unique case (key_size_e'(size_i))
      KSZ_128: last_d = CNT_W'(1);
      KSZ_192: last_d = CNT_W'(2);
      default: last_d = CNT_W'(MAX_CHUNKS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == last_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_q && start_i) key_q <= key_i;
  end

  tf_rs_chunk_sel #(.NUM_CHUNKS(MAX_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES)) u_sel (
    .key(key_q), .sel(cnt_q), .chunk(chunk)
  );

  tf_rs_matrix #(.POLY(POLY)) u_mat (
    .m(chunk), .s(s_word)
  );

  tf_rs_wordfile #(.DEPTH(MAX_CHUNKS), .W(WORD_W)) u_words (
    .clk(clk), .we(busy_q), .widx(cnt_q), .wdata(s_word),
    .ridx(rd_idx_i), .rdata(rd_word_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/tf_rs_keygen_chk.sv
module tf_rs_keygen_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last
);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R5
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i) |=> (busy && !done));

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != last) |=> (busy && cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == last) |=> (done && !busy));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start_i) |=> done);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && !busy && cnt == '0));
endmodule

bind tf_rs_keygen tf_rs_keygen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy_q),
  .done(done_q), .cnt(cnt_q), .last(last_q)
);

// File: tb/test_tf_rs_keygen.sv
module test_tf_rs_keygen;
  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [1:0]   size_i;
  logic [255:0] key_i;
  logic         done_o;
  logic [1:0]   rd_idx_i;
  logic [31:0]  rd_word_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tf_rs_keygen i_tf_rs_keygen (
    .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .key_i(key_i),
    .done_o(done_o), .rd_idx_i(rd_idx_i), .rd_word_o(rd_word_o)
  );

  localparam logic [7:0] RSM [4][8] = '{
    '{8'h01, 8'hA4, 8'h55, 8'h87, 8'h5A, 8'h58, 8'hDB, 8'h9E},
    '{8'hA4, 8'h56, 8'h82, 8'hF3, 8'h1E, 8'hC6, 8'h68, 8'hE5},
    '{8'h02, 8'hA1, 8'hFC, 8'hC1, 8'h47, 8'hAE, 8'h3D, 8'h19},
    '{8'hA4, 8'h55, 8'h87, 8'h5A, 8'h58, 8'hDB, 8'h9E, 8'h03}
  };

  // independent model: MSB-first Horner product
  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = p[7] ? ((p << 1) ^ 8'h4D) : (p << 1);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [31:0] ref_word(logic [255:0] k, int c);
    logic [31:0] w = '0;
    for (int r = 0; r < 4; r++) begin
      logic [7:0] acc = 8'h00;
      for (int j = 0; j < 8; j++)
        acc = acc ^ ref_mul(RSM[r][j], k[255 - 8*(8*c + j) -: 8]);
      w[8*r +: 8] = acc;
    end
    return w;
  endfunction

  function automatic int nwords(logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 3 : 4;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_word(int idx, output logic [31:0] w);
    rd_idx_i = 2'(idx);
    #1 w = rd_word_o;
  endtask

  // start at a falling edge; check done stays low N cycles then rises (R4)
  task automatic do_run(logic [255:0] k, logic [1:0] s);
    int n = nwords(s);
    key_i = k; size_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    key_i = ~k; size_i = ~s;
    for (int i = 0; i < n; i++) begin
      check("R4 busy done low", 32'(done_o), 32'd0);
      @(negedge clk);
    end
    check("R4 done latency", 32'(done_o), 32'd1);
  endtask

  localparam int NV = 7;
  localparam logic [255:0] V_KEY [NV] = '{
    {8'h01, 248'h0},
    {56'h0, 8'h01, 192'h0},
    {8'h00, 8'h01, 240'h0},
    {8'h02, 248'h0},
    {64'h0, 8'h01, 184'h0},
    {192'h0, 8'h01, 56'h0},
    {128'h0, 8'h01, 48'h0, 8'h01, 64'h0}
  };
  localparam logic [1:0] V_SIZE [NV] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2, 2'd1};
  // {S3,S2,S1,S0}
  localparam logic [127:0] V_EXP [NV] = '{
    {64'h0, 32'h0, 32'hA402A401},
    {64'h0, 32'h0, 32'h0319E59E},
    {32'h0, 32'h0, 32'h0, 32'h55A156A4},
    {64'h0, 32'h0, 32'h05040502},
    {64'h0, 32'hA402A401, 32'h0},
    {32'hA402A401, 32'h0, 32'h0, 32'h0},
    {32'h0, 32'hA71B419F, 32'h0, 32'h0}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0]  w;
    logic [255:0] ka;
    rst = 1'b1; start_i = 1'b0; size_i = 2'd0; key_i = '0; rd_idx_i = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 reset done", 32'(done_o), 32'd0);

    // R1 R2 R3: literal column vectors
    for (int v = 0; v < NV; v++) begin
      do_run(V_KEY[v], V_SIZE[v]);
      for (int c = 0; c < nwords(V_SIZE[v]); c++) begin
        read_word(c, w);
        check("R1 R2 R3 vector word", w, V_EXP[v][32*c +: 32]);
      end
    end

    // R2 R3: dense keys at every size code, low bits filled with garbage
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        logic [255:0] k;
        for (int q = 0; q < 8; q++)
          k[32*q +: 32] = 32'h9E3779B9 * (t*8 + q + 1) ^ 32'h5A5A0F0F * s;
        do_run(k, 2'(s));
        for (int c = 0; c < nwords(2'(s)); c++) begin
          read_word(c, w);
          check("R2 R3 model word", w, ref_word(k, c));
        end
      end
    end

    // R6: shorter run keeps upper words
    ka = {8{32'hC0FFEE11}} ^ {32{8'h3C}};
    do_run(ka, 2'd2);
    do_run('0, 2'd0);
    read_word(0, w); check("R6 new S0", w, 32'h0);
    read_word(1, w); check("R6 new S1", w, 32'h0);
    read_word(2, w); check("R6 kept S2", w, ref_word(ka, 2));
    read_word(3, w); check("R6 kept S3", w, ref_word(ka, 3));
    repeat (3) @(negedge clk);
    check("R6 done held", 32'(done_o), 32'd1);

    // R5: second start during run with new key and size
    key_i = ka; size_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; key_i = ~ka; size_i = 2'd0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R5 no done yet", 32'(done_o), 32'd0);
    @(negedge clk);
    check("R5 no done yet", 32'(done_o), 32'd0);
    @(negedge clk);
    check("R5 done at original time", 32'(done_o), 32'd1);
    for (int c = 0; c < 4; c++) begin
      read_word(c, w);
      check("R5 words from first key", w, ref_word(ka, c));
    end

    // R7: reset mid-run, then a normal run
    key_i = ka; size_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 reset mid-run", 32'(done_o), 32'd0);
    repeat (5) @(negedge clk);
    check("R7 stays idle", 32'(done_o), 32'd0);
    do_run(~ka, 2'd1);
    for (int c = 0; c < 3; c++) begin
      read_word(c, w);
      check("R7 run after reset", w, ref_word(~ka, c));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule